// File: doc/BRIEF.md
# Priority-Level Autovectored Interrupt Controller

This block takes eight interrupt request lines, one per priority level, with level 0 the most urgent and level 7 the least urgent. It holds the current interrupt priority level (IPL), which is a threshold. A request on level `i` is recognised only while `i` is below the IPL. The CPU interrupt request is driven combinationally from the recognised lines. When the CPU acknowledges, the block computes the vector from the winning level (`BASE_VECTOR + level`) and holds it. In the same clock edge it raises the IPL to the level being serviced and saves the previous IPL on a small hardware stack.

A return strobe pops the saved IPL back into place. This gives nested interrupts with no software work: a more urgent request still passes the raised threshold and can preempt a handler that is already running. Software can also load the IPL directly, for example to mask everything (IPL = 0) around a critical sequence. The reset IPL is 8, so every level is enabled.

The stack holds 4 entries. Its fill is tracked by a three-state machine:

- `STK_EMPTY` moves to `STK_PARTIAL` on a push. With a depth of one it moves straight to `STK_FULL`.
- `STK_PARTIAL` moves to `STK_FULL` on a push that fills the last slot.
- `STK_PARTIAL` moves to `STK_EMPTY` on a pop that removes the last entry.
- `STK_FULL` moves to `STK_PARTIAL` on a pop.
- `STK_FULL` stays in `STK_FULL` on a push. Such a push is an overflow: the oldest saved IPL is dropped and a sticky flag is raised.

Top module: `irq_autovec_ctrl`

## Requirements
- R1: After reset the IPL is 8, the vector is 0, the overflow flag is 0 and the interrupt request is low while no request line is set.
- R2: `int_req` is high in the same cycle, combinationally, exactly when some `irq_req[i]` is 1 with `i` less than the current IPL.
- R3: A request line whose index is equal to or greater than the IPL is ignored. An IPL of 0 masks every line.
- R4: An accepted acknowledge is `ack` high while `int_req` is high. After an accepted acknowledge, from the next cycle, `vector` equals `BASE_VECTOR + w` and the IPL equals `w`, where `w` is the lowest recognised index at that edge.
- R5: The vector changes only on an accepted acknowledge. Later changes on the request lines, and an `ack` given while `int_req` is low, leave it unchanged.
- R6: Each accepted acknowledge saves the previous IPL. Each `ret` with a non-empty stack restores the most recently saved IPL on the next cycle. A `ret` with an empty stack is ignored.
- R7: A fifth nested acknowledge with four IPLs saved sets `stk_ovf`. The flag stays set until reset. The oldest saved IPL is lost and the newest four are kept.
- R8: `ipl_wr` loads `ipl_wdata` into the IPL on the next cycle. When several inputs act in the same cycle, the order of precedence is: accepted acknowledge first, then an effective `ret`, then `ipl_wr`.
- R9: While a handler at level L runs, a request at a level below L raises `int_req`, and acknowledging it nests to that level. Returning twice restores L and then the original IPL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Request lines, bit i = priority level i (0 most urgent) |
| ack | input | 1 | CPU interrupt acknowledge |
| ret | input | 1 | Return-from-handler strobe |
| ipl_wr | input | 1 | Software IPL load strobe |
| ipl_wdata | input | 4 | Value for a software IPL load |
| int_req | output | 1 | Interrupt request to the CPU |
| vector | output | 8 | Autovector latched on accepted acknowledge |
| ipl | output | 4 | Current interrupt priority level |
| stk_ovf | output | 1 | Sticky nesting-overflow flag |

## Verification
A wrong IPL shows at once on `int_req`: the very next request pattern is either recognised or masked wrongly in the same cycle. The bench therefore sweeps every request pattern against every IPL value from 0 to 8. A corrupted stack entry stays hidden until the matching return. It then appears on `ipl` one cycle after `ret`, so the bench checks the restored IPL after each return, including the return after an overflow that dropped the oldest entry. A wrong priority pick shows in `vector` and `ipl` one cycle after the acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        STK_EMPTY   = 2'd0,
        STK_PARTIAL = 2'd1,
        STK_FULL    = 2'd2
    } stk_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_LEVELS = 8,
    parameter int LVL_W      = 4
) (
    input  logic [NUM_LEVELS-1:0] req,
    input  logic [LVL_W-1:0]      thresh,
    output logic                  any,
    output logic [LVL_W-1:0]      level
);
    logic [NUM_LEVELS-1:0] enabled;

    // A line is recognised only below the current threshold
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_mask
        assign enabled[i] = req[i] && (LVL_W'(i) < thresh);
    end

    // Lowest recognised index wins
    always_comb begin
        level = '0;
        for (int k = NUM_LEVELS - 1; k >= 0; k--) begin
            if (enabled[k]) level = LVL_W'(k);
        end
    end

    assign any = |enabled;
endmodule

// File: rtl/ipl_stack.sv
module ipl_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_val,
    output logic [LVL_W-1:0] top_val,
    output logic             empty,
    output logic             ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    stk_state_e       state, state_nx;
    logic [CNT_W-1:0] count;
    logic [LVL_W-1:0] mem [DEPTH];
    logic             do_pop;

    assign do_pop = pop && !push && (state != STK_EMPTY);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            STK_EMPTY:   if (push) state_nx = (DEPTH == 1) ? STK_FULL : STK_PARTIAL;
            STK_PARTIAL: begin
                if (push && count == CNT_W'(DEPTH - 1))   state_nx = STK_FULL;
                else if (do_pop && count == CNT_W'(1))    state_nx = STK_EMPTY;
            end
            STK_FULL:    if (do_pop) state_nx = (DEPTH == 1) ? STK_EMPTY : STK_PARTIAL;
            default:     state_nx = STK_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= STK_EMPTY;
        else        state <= state_nx;
    end

    // Storage, fill count and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (push) begin
            for (int k = DEPTH - 1; k > 0; k--) mem[k] <= mem[k-1];
            mem[0] <= push_val;
            if (state == STK_FULL) ovf   <= 1'b1;
            else                   count <= count + CNT_W'(1);
        end else if (do_pop) begin
            for (int k = 0; k < DEPTH - 1; k++) mem[k] <= mem[k+1];
            mem[DEPTH-1] <= '0;
            count        <= count - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        top_val = mem[0];
        empty   = (state == STK_EMPTY);
    end

    a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r6_empty_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STK_EMPTY) == (count == '0));
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    a_r7_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(state) == STK_FULL);
endmodule

// File: rtl/irq_autovec_ctrl.sv
module irq_autovec_ctrl #(
    parameter int          NUM_LEVELS  = 8,
    parameter int          STACK_DEPTH = 4,
    parameter int          VEC_W       = 8,
    parameter logic [7:0]  BASE_VECTOR = 8'h40,
    localparam int         LVL_W       = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-1:0] irq_req,
    input  logic                  ack,
    input  logic                  ret,
    input  logic                  ipl_wr,
    input  logic [LVL_W-1:0]      ipl_wdata,
    output logic                  int_req,
    output logic [VEC_W-1:0]      vector,
    output logic [LVL_W-1:0]      ipl,
    output logic                  stk_ovf
);
    logic             pick_any;
    logic [LVL_W-1:0] pick_lvl;
    logic [LVL_W-1:0] stk_top;
    logic             stk_empty;
    logic             accept;
    logic             do_ret;

    irq_prio_pick #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_pick (
        .req    (irq_req),
        .thresh (ipl),
        .any    (pick_any),
        .level  (pick_lvl)
    );

    assign int_req = pick_any;
    assign accept  = ack && pick_any;
    assign do_ret  = ret && !accept && !stk_empty;

    ipl_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .pop      (do_ret),
        .push_val (ipl),
        .top_val  (stk_top),
        .empty    (stk_empty),
        .ovf      (stk_ovf)
    );

    // IPL and vector registers: acknowledge, then return, then software load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipl    <= LVL_W'(NUM_LEVELS);
            vector <= '0;
        end else if (accept) begin
            ipl    <= pick_lvl;
            vector <= VEC_W'(BASE_VECTOR) + VEC_W'(pick_lvl);
        end else if (do_ret) begin
            ipl    <= stk_top;
        end else if (ipl_wr) begin
            ipl    <= ipl_wdata;
        end
    end

    a_r3_zero_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl == '0) |-> !int_req);
    a_r2_req_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (irq_req != '0));
    a_r4_ipl_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req) |=> (ipl < $past(ipl)) &&
                             (vector == VEC_W'(BASE_VECTOR) + VEC_W'(ipl)));
    a_r5_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && int_req) |=> $stable(vector));
endmodule

// File: tb/test_irq_autovec_ctrl.sv
module test_irq_autovec_ctrl;
    localparam int BASE = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       ack = 1'b0, ret = 1'b0, ipl_wr = 1'b0;
    logic [3:0] ipl_wdata = '0;
    logic       int_req;
    logic [7:0] vector;
    logic [3:0] ipl;
    logic       stk_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int exp_vec = 0;

    always #2 clk = ~clk;

    irq_autovec_ctrl i_irq_autovec_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ack(ack), .ret(ret),
        .ipl_wr(ipl_wr), .ipl_wdata(ipl_wdata), .int_req(int_req),
        .vector(vector), .ipl(ipl), .stk_ovf(stk_ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ipl(input int v);
        ipl_wr = 1'b1; ipl_wdata = 4'(v);
        step();
        ipl_wr = 1'b0;
    endtask

    task automatic do_ack(input int lvl);
        ack = 1'b1;
        step();
        ack = 1'b0;
        exp_vec = BASE + lvl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 ipl", ipl, 8);
        chk("R1 vector", vector, 0);
        chk("R1 ovf", stk_ovf, 0);
        chk("R1 int_req", int_req, 0);

        // R2 R3 R4 R5 R6 R8: sweep every IPL 0..8 against every request pattern
        for (int ip = 0; ip <= 8; ip++) begin
            for (int p = 0; p < 256; p++) begin
                int w;
                bit e;
                set_ipl(ip);
                chk("R8 ipl load", ipl, ip);
                irq_req = 8'(p);
                #1;
                e = 1'b0; w = 0;
                for (int k = 7; k >= 0; k--)
                    if (p[k] && k < ip) begin e = 1'b1; w = k; end
                chk("R2 R3 int_req", int_req, int'(e));
                ack = 1'b1;
                step();
                ack = 1'b0;
                if (e) begin
                    exp_vec = BASE + w;
                    chk("R4 vector", vector, exp_vec);
                    chk("R4 ipl", ipl, w);
                    irq_req = ~8'(p);
                    #1;
                    chk("R5 vector held", vector, exp_vec);
                    ret = 1'b1;
                    step();
                    ret = 1'b0;
                    chk("R6 restore", ipl, ip);
                end else begin
                    chk("R5 ignored ack vector", vector, exp_vec);
                    chk("R5 ignored ack ipl", ipl, ip);
                end
            end
        end
        irq_req = '0;

        // R9 nested preemption
        set_ipl(8);
        irq_req = 8'b0010_0000;
        do_ack(5);
        chk("R9 first level", ipl, 5);
        irq_req = 8'b0010_0100;
        #1;
        chk("R9 preempt req", int_req, 1);
        do_ack(2);
        chk("R9 nested vector", vector, BASE + 2);
        chk("R9 nested ipl", ipl, 2);
        irq_req = 8'b0010_0000;
        #1;
        chk("R9 lower blocked", int_req, 0);
        ret = 1'b1; step(); ret = 1'b0;
        chk("R9 back to 5", ipl, 5);
        ret = 1'b1; step(); ret = 1'b0;
        chk("R9 back to 8", ipl, 8);
        ret = 1'b1; step(); ret = 1'b0;
        chk("R6 empty ret ignored", ipl, 8);
        irq_req = '0;

        // R8 precedence
        irq_req = 8'b0000_1000;
        ack = 1'b1; ret = 1'b1; ipl_wr = 1'b1; ipl_wdata = 4'd0;
        step();
        ack = 1'b0; ret = 1'b0; ipl_wr = 1'b0;
        exp_vec = BASE + 3;
        chk("R8 ack wins ipl", ipl, 3);
        chk("R8 ack wins vector", vector, exp_vec);
        irq_req = '0;
        ret = 1'b1; ipl_wr = 1'b1; ipl_wdata = 4'd1;
        step();
        ret = 1'b0; ipl_wr = 1'b0;
        chk("R8 ret over write", ipl, 8);
        ret = 1'b1; ipl_wr = 1'b1; ipl_wdata = 4'd2;
        step();
        ret = 1'b0; ipl_wr = 1'b0;
        chk("R8 write when ret empty", ipl, 2);
        set_ipl(0);
        irq_req = 8'hFF;
        #1;
        chk("R3 ipl0 masks all", int_req, 0);
        irq_req = '0;

        // R7 overflow: nest 7,6,5,4,3 from IPL 8
        set_ipl(8);
        for (int lv = 7; lv >= 3; lv--) begin
            irq_req = 8'(1 << lv);
            do_ack(lv);
            chk("R7 nest ipl", ipl, lv);
            if (lv == 4) chk("R7 no ovf at depth 4", stk_ovf, 0);
        end
        chk("R7 ovf set", stk_ovf, 1);
        irq_req = '0;
        for (int lv = 4; lv <= 7; lv++) begin
            ret = 1'b1; step(); ret = 1'b0;
            chk("R7 kept newest", ipl, lv);
        end
        ret = 1'b1; step(); ret = 1'b0;
        chk("R7 oldest lost", ipl, 7);
        chk("R7 ovf sticky", stk_ovf, 1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule